// File: doc/BRIEF.md
# Saturating 64-by-32 Integer Divider

This unit is the multi-cycle divide engine of a 32-bit integer datapath. A 64-bit dividend is built by putting a 32-bit Y register value above the low word of operand A. It is divided by the low word of operand B. Unsigned and signed (two's complement) modes are available. The quotient comes out as 32 bits. When the true quotient does not fit in 32 bits, the unit does not wrap. It clamps the quotient to the nearest representable limit and raises an overflow flag.

A request is issued by pulsing `start_i` while the unit is idle. `busy_o` stays high while the unit iterates. `done_o` pulses for one cycle when the quotient, overflow flag and trap flag are valid. A divisor of zero is refused at once: the trap flag is raised and no result is written anywhere. When the request sets the condition-code option, the committed quotient and overflow bit are also copied into a separate condition-code snapshot. Without the option, that snapshot keeps its old value.

Top module: `sat_divider`

## Requirements
- R1: The dividend is {y_i[31:0], a_i[31:0]} and the divisor is b_i[31:0]. Bits 63:32 of a_i and b_i have no effect on any output.
- R2: If b_i[31:0] is zero when a start is accepted, done_o rises in the next cycle with dz_trap_o = 1 and busy_o never rises. quot_o, ovf_o, cc_quot_o and cc_ovf_o keep their previous values.
- R3: In unsigned mode (signed_i = 0), a quotient above 0xFFFFFFFF gives quot_o = 0xFFFFFFFF with ovf_o = 1. Otherwise the exact quotient is given with ovf_o = 0.
- R4: In signed mode (signed_i = 1), a quotient outside -2^31..2^31-1 gives quot_o = 0x80000000 if negative, or 0x7FFFFFFF if positive, with ovf_o = 1. Otherwise ovf_o = 0.
- R5: Signed division truncates toward zero, so the quotient is negative exactly when a non-zero magnitude quotient has operands of differing sign.
- R6: On a successful divide with cc_en_i = 1 at start, cc_quot_o and cc_ovf_o take the new quot_o and ovf_o in the cycle done_o is high. With cc_en_i = 0, they are unchanged.
- R7: For a non-zero divisor, busy_o is high for the 65 cycles after the accepted start. done_o is high for exactly one cycle, the cycle right after busy_o falls. On a successful completion, dz_trap_o is 0.
- R8: A start_i pulse while busy_o is high is ignored: the running divide completes with its original operands and timing.
- R9: While rst_n is low at a clock edge, all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request pulse, accepted only while idle |
| signed_i | input | 1 | 1 = signed divide, 0 = unsigned |
| cc_en_i | input | 1 | 1 = copy result into the condition-code snapshot |
| y_i | input | 32 | Upper dividend word |
| a_i | input | 64 | Operand A; low word is the lower dividend word |
| b_i | input | 64 | Operand B; low word is the divisor |
| busy_o | output | 1 | Divide in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 32 | Saturated quotient of the last successful divide |
| ovf_o | output | 1 | Quotient was clamped |
| dz_trap_o | output | 1 | Last request had a zero divisor |
| cc_quot_o | output | 32 | Condition-code snapshot of the quotient |
| cc_ovf_o | output | 1 | Condition-code snapshot of the overflow bit |

## Verification
Some properties are checked on every cycle. The done pulse is one cycle long and never overlaps busy. A trap completion freezes the result and the condition-code snapshot. A request without the option leaves the snapshot unchanged. A clamped unsigned result is all ones, and a clamped signed result is one of the two limits. The partial remainder always stays below the divisor, and the divisor register holds steady while iterating. Other behaviour only the bench scenarios can show, because it needs an independent model of the arithmetic. That covers the exact quotient value, where the saturation boundaries lie, truncation toward zero, the masking of the upper operand bits, and the fact that a start during a divide is dropped.

// File: rtl/sat_div_pkg.sv
// Shared definitions for the saturating divider.
// Assumes: only the control state encoding is shared between modules.
package sat_div_pkg;
    typedef enum logic [1:0] {
        DV_IDLE = 2'd0,
        DV_RUN  = 2'd1,
        DV_FIN  = 2'd2
    } dv_state_e;
endpackage

// File: rtl/div_operand_prep.sv
// Forms the double-width dividend and the divisor from the request inputs,
// and converts them to magnitudes in signed mode.
// Assumes: OW >= DW; operand bits above DW are ignored.
module div_operand_prep #(
    parameter int DW = 32,
    parameter int OW = 64
) (
    input  logic [DW-1:0]   y_i,
    input  logic [OW-1:0]   a_i,
    input  logic [OW-1:0]   b_i,
    input  logic            signed_i,
    output logic [2*DW-1:0] dvd_mag_o,
    output logic [DW-1:0]   dvs_mag_o,
    output logic            neg_o,
    output logic            dvs_zero_o
);
    localparam int QW = 2 * DW;

    logic [QW-1:0] dvd_raw;
    logic [DW-1:0] dvs_raw;
    logic          unused_hi;

    assign dvd_raw   = {y_i, a_i[DW-1:0]};
    assign dvs_raw   = b_i[DW-1:0];
    assign unused_hi = ^{a_i[OW-1:DW], b_i[OW-1:DW]};

    // Take magnitudes and the result sign for signed requests.
    always_comb begin
        dvd_mag_o  = dvd_raw;
        dvs_mag_o  = dvs_raw;
        neg_o      = 1'b0;
        dvs_zero_o = (dvs_raw == '0);
        if (signed_i) begin
            if (dvd_raw[QW-1]) dvd_mag_o = ~dvd_raw + 1'b1;
            if (dvs_raw[DW-1]) dvs_mag_o = ~dvs_raw + 1'b1;
            neg_o = dvd_raw[QW-1] ^ dvs_raw[DW-1];
        end
    end
endmodule

// File: rtl/div_restoring_core.sv
// Restoring radix-2 divider: one quotient bit per step over a double-width
// magnitude dividend, with a DW+1 bit trial remainder.
// Assumes: the divisor loaded is non-zero; step is not asserted with load.
module div_restoring_core #(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            step_i,
    input  logic [2*DW-1:0] dvd_i,
    input  logic [DW-1:0]   dvs_i,
    output logic [2*DW-1:0] quo_o
);
    localparam int QW = 2 * DW;

    logic [DW-1:0] rem_q;
    logic [QW-1:0] shf_q;
    logic [DW-1:0] dvs_q;
    logic [DW:0]   trial;
    logic [DW:0]   diff;
    logic          take;

    assign trial = {rem_q, shf_q[QW-1]};
    assign diff  = trial - {1'b0, dvs_q};
    assign take  = (trial >= {1'b0, dvs_q});
    assign quo_o = shf_q;

    // Load operands, then shift in one quotient bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            shf_q <= '0;
            dvs_q <= '0;
        end else if (load_i) begin
            rem_q <= '0;
            shf_q <= dvd_i;
            dvs_q <= dvs_i;
        end else if (step_i) begin
            rem_q <= take ? diff[DW-1:0] : trial[DW-1:0];
            shf_q <= {shf_q[QW-2:0], take};
        end
    end

    // R3
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(step_i) |-> (rem_q < dvs_q));

    // R8
    dvs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && $past(step_i)) |-> $stable(dvs_q));
endmodule

// File: rtl/div_saturate.sv
// Clamps a double-width magnitude quotient into DW bits and applies the sign.
// Assumes: neg_i is only set in signed mode.
module div_saturate #(
    parameter int DW = 32
) (
    input  logic [2*DW-1:0] qmag_i,
    input  logic            signed_i,
    input  logic            neg_i,
    output logic [DW-1:0]   quot_o,
    output logic            ovf_o
);
    localparam int QW = 2 * DW;
    localparam logic [DW-1:0] S_MIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] S_MAX = {1'b0, {(DW-1){1'b1}}};

    logic hi_any;

    assign hi_any = |qmag_i[QW-1:DW];

    // Select the limit and the overflow flag per mode and sign.
    always_comb begin
        if (!signed_i) begin
            ovf_o  = hi_any;
            quot_o = hi_any ? '1 : qmag_i[DW-1:0];
        end else if (neg_i) begin
            ovf_o  = hi_any || (qmag_i[DW-1] && (|qmag_i[DW-2:0]));
            quot_o = ovf_o ? S_MIN : (~qmag_i[DW-1:0] + 1'b1);
        end else begin
            ovf_o  = hi_any || qmag_i[DW-1];
            quot_o = ovf_o ? S_MAX : qmag_i[DW-1:0];
        end
    end
endmodule

// File: rtl/sat_divider.sv
// Top of the saturating divider: accepts a request, traps zero divisors,
// runs 2*DW restoring steps, then commits the clamped result in one more
// cycle and optionally copies it into the condition-code snapshot.
// Assumes: requests arrive as start pulses; a start while busy is dropped.
module sat_divider #(
    parameter int DATA_W = 32,
    parameter int OPND_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              signed_i,
    input  logic              cc_en_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic [OPND_W-1:0] a_i,
    input  logic [OPND_W-1:0] b_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] quot_o,
    output logic              ovf_o,
    output logic              dz_trap_o,
    output logic [DATA_W-1:0] cc_quot_o,
    output logic              cc_ovf_o
);
    import sat_div_pkg::*;

    localparam int QW    = 2 * DATA_W;
    localparam int CNT_W = $clog2(QW);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(QW - 1);
    localparam logic [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};

    dv_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              sgn_q, neg_q, cc_q;
    logic              done_q, ovf_q, dz_q, cc_ovf_q;
    logic [DATA_W-1:0] quot_q, cc_quot_q;

    logic [QW-1:0]     dvd_mag;
    logic [DATA_W-1:0] dvs_mag;
    logic              neg_in, dvs_zero;
    logic              accept, load, step;
    logic [QW-1:0]     qmag;
    logic [DATA_W-1:0] sat_quot;
    logic              sat_ovf;

    div_operand_prep #(.DW(DATA_W), .OW(OPND_W)) u_prep (
        .y_i        (y_i),
        .a_i        (a_i),
        .b_i        (b_i),
        .signed_i   (signed_i),
        .dvd_mag_o  (dvd_mag),
        .dvs_mag_o  (dvs_mag),
        .neg_o      (neg_in),
        .dvs_zero_o (dvs_zero)
    );

    assign accept = (state_q == DV_IDLE) && start_i;
    assign load   = accept && !dvs_zero;
    assign step   = (state_q == DV_RUN);

    div_restoring_core #(.DW(DATA_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .step_i (step),
        .dvd_i  (dvd_mag),
        .dvs_i  (dvs_mag),
        .quo_o  (qmag)
    );

    div_saturate #(.DW(DATA_W)) u_sat (
        .qmag_i   (qmag),
        .signed_i (sgn_q),
        .neg_i    (neg_q),
        .quot_o   (sat_quot),
        .ovf_o    (sat_ovf)
    );

    // Control sequence, result commit and condition-code snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= DV_IDLE;
            cnt_q     <= '0;
            sgn_q     <= 1'b0;
            neg_q     <= 1'b0;
            cc_q      <= 1'b0;
            done_q    <= 1'b0;
            quot_q    <= '0;
            ovf_q     <= 1'b0;
            dz_q      <= 1'b0;
            cc_quot_q <= '0;
            cc_ovf_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                DV_IDLE: begin
                    if (accept && dvs_zero) begin
                        done_q <= 1'b1;
                        dz_q   <= 1'b1;
                    end else if (load) begin
                        state_q <= DV_RUN;
                        cnt_q   <= '0;
                        sgn_q   <= signed_i;
                        neg_q   <= neg_in;
                        cc_q    <= cc_en_i;
                    end
                end
                DV_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) state_q <= DV_FIN;
                end
                DV_FIN: begin
                    quot_q  <= sat_quot;
                    ovf_q   <= sat_ovf;
                    dz_q    <= 1'b0;
                    done_q  <= 1'b1;
                    state_q <= DV_IDLE;
                    if (cc_q) begin
                        cc_quot_q <= sat_quot;
                        cc_ovf_q  <= sat_ovf;
                    end
                end
                default: state_q <= DV_IDLE;
            endcase
        end
    end

    assign busy_o    = (state_q != DV_IDLE);
    assign done_o    = done_q;
    assign quot_o    = quot_q;
    assign ovf_o     = ovf_q;
    assign dz_trap_o = dz_q;
    assign cc_quot_o = cc_quot_q;
    assign cc_ovf_o  = cc_ovf_q;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R2
    dz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && dz_trap_o) |-> ($stable(quot_o) && $stable(ovf_o)
                                   && $stable(cc_quot_o) && $stable(cc_ovf_o)));

    // R6
    cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !dz_trap_o && !cc_q) |-> ($stable(cc_quot_o) && $stable(cc_ovf_o)));

    // R3
    usat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !dz_trap_o && ovf_o && !sgn_q) |-> (quot_o == '1));

    // R4
    ssat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !dz_trap_o && ovf_o && sgn_q) |-> ((quot_o == S_MIN) || (quot_o == S_MAX)));
endmodule

// File: tb/tb_sat_divider.sv
// Bench: behavioural reference model stepped on every clock and compared
// against all outputs at each falling edge.
module tb_sat_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, signed_i = 1'b0, cc_en_i = 1'b0;
    logic [31:0] y_i = '0;
    logic [63:0] a_i = '0, b_i = '0;
    logic        busy_o, done_o, ovf_o, dz_trap_o, cc_ovf_o;
    logic [31:0] quot_o, cc_quot_o;

    sat_divider dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .cc_en_i(cc_en_i), .y_i(y_i), .a_i(a_i), .b_i(b_i),
        .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o), .ovf_o(ovf_o),
        .dz_trap_o(dz_trap_o), .cc_quot_o(cc_quot_o), .cc_ovf_o(cc_ovf_o)
    );

    always #5 clk = ~clk;

    int    n_cmp = 0, n_bad = 0, cyc = 0;
    string cur_req = "R9";
    bit    chk_en = 1'b0;

    // Model state
    int          e_cnt = 0;
    logic        e_busy = 0, e_done = 0, e_ovf = 0, e_dz = 0, e_cco = 0;
    logic [31:0] e_quot = 0, e_ccq = 0;
    logic [31:0] p_q;
    logic        p_o, p_cc;

    function automatic logic [32:0] ref_div(input logic sg, input logic [31:0] y,
                                            input logic [31:0] a, input logic [31:0] b);
        logic [63:0] dvd, md, qm;
        logic [31:0] ms;
        logic        ng;
        dvd = {y, a};
        if (!sg) begin
            qm = dvd / {32'd0, b};
            if (qm > 64'hFFFF_FFFF) return {1'b1, 32'hFFFF_FFFF};
            return {1'b0, qm[31:0]};
        end
        ng = dvd[63] ^ b[31];
        md = dvd[63] ? (~dvd + 64'd1) : dvd;
        ms = b[31] ? (~b + 32'd1) : b;
        qm = md / {32'd0, ms};
        if (ng) begin
            if (qm > 64'h8000_0000) return {1'b1, 32'h8000_0000};
            return {1'b0, 32'd0 - qm[31:0]};
        end
        if (qm > 64'h7FFF_FFFF) return {1'b1, 32'h7FFF_FFFF};
        return {1'b0, qm[31:0]};
    endfunction

    // Reference model, advanced at each rising edge.
    always @(posedge clk) begin
        logic [32:0] r;
        chk_en = 1'b1;
        if (!rst_n) begin
            e_cnt = 0; e_done = 0; e_quot = 0; e_ovf = 0; e_dz = 0; e_ccq = 0; e_cco = 0;
        end else begin
            e_done = 0;
            if (e_cnt > 0) begin
                e_cnt--;
                if (e_cnt == 0) begin
                    e_done = 1; e_quot = p_q; e_ovf = p_o; e_dz = 0;
                    if (p_cc) begin e_ccq = p_q; e_cco = p_o; end
                end
            end else if (start_i) begin
                if (b_i[31:0] == 0) begin
                    e_done = 1; e_dz = 1;
                end else begin
                    r = ref_div(signed_i, y_i, a_i[31:0], b_i[31:0]);
                    p_o = r[32]; p_q = r[31:0]; p_cc = cc_en_i;
                    e_cnt = 65;
                end
            end
        end
        e_busy = (e_cnt > 0);
    end

    task automatic cmp1(input string nm, input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %h expected %h", cur_req, nm, cyc, act, exp);
        end
    endtask

    // Compare every output at each falling edge.
    always @(negedge clk) begin
        if (chk_en) begin
            n_cmp++;
            cmp1("busy", {31'd0, busy_o}, {31'd0, e_busy});
            cmp1("done", {31'd0, done_o}, {31'd0, e_done});
            cmp1("quot", quot_o, e_quot);
            cmp1("ovf", {31'd0, ovf_o}, {31'd0, e_ovf});
            cmp1("dz", {31'd0, dz_trap_o}, {31'd0, e_dz});
            cmp1("ccq", cc_quot_o, e_ccq);
            cmp1("cco", {31'd0, cc_ovf_o}, {31'd0, e_cco});
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL %s watchdog expired", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic issue(input string tag, input logic sg, input logic cc,
                         input logic [31:0] y, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        cur_req = tag;
        start_i = 1'b1; signed_i = sg; cc_en_i = cc; y_i = y; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic finish_div();
        while (!done_o) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_div(input string tag, input logic sg, input logic cc,
                          input logic [31:0] y, input logic [63:0] a, input logic [63:0] b);
        issue(tag, sg, cc, y, a, b);
        finish_div();
    endtask

    initial begin
        cur_req = "R9";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R3 / R6 basic unsigned with snapshot
        do_div("R6", 0, 1, 32'd0, 64'd100, 64'd7);
        // R1 upper operand bits ignored
        do_div("R1", 0, 1, 32'd0, 64'hDEAD_BEEF_0000_0064, 64'hFFFF_FFFF_0000_0007);
        // R3 boundaries
        do_div("R3", 0, 0, 32'd0, 64'hFFFF_FFFF, 64'd1);
        do_div("R3", 0, 1, 32'd1, 64'd0, 64'd2);
        do_div("R3", 0, 1, 32'd1, 64'd0, 64'd1);
        do_div("R3", 0, 1, 32'hFFFF_FFFF, 64'hFFFF_FFFF, 64'hFFFF_FFFF);
        // R5 truncation toward zero
        do_div("R5", 1, 1, 32'hFFFF_FFFF, 64'hFFFF_FF9C, 64'd7);
        do_div("R5", 1, 1, 32'd0, 64'd100, 64'hFFFF_FFF9);
        do_div("R5", 1, 0, 32'hFFFF_FFFF, 64'hFFFF_FF9C, 64'hFFFF_FFF9);
        // R4 signed limits
        do_div("R4", 1, 1, 32'd0, 64'h8000_0000, 64'd1);
        do_div("R4", 1, 1, 32'hFFFF_FFFF, 64'h8000_0000, 64'd1);
        do_div("R4", 1, 1, 32'hFFFF_FFFF, 64'h7FFF_FFFF, 64'd1);
        do_div("R4", 1, 1, 32'h8000_0000, 64'd0, 64'hFFFF_FFFF);
        do_div("R4", 1, 0, 32'd0, 64'h7FFF_FFFF, 64'd1);
        // R2 zero divisor with non-zero upper B bits and snapshot requested
        do_div("R2", 0, 1, 32'd5, 64'd9, 64'hFFFF_FFFF_0000_0000);
        do_div("R2", 1, 1, 32'd0, 64'd9, 64'd0);
        // R6 request without option leaves snapshot
        do_div("R6", 0, 0, 32'd0, 64'd1000, 64'd3);
        // R8 start during busy is dropped
        issue("R8", 0, 1, 32'd0, 64'd5000, 64'd9);
        repeat (10) @(negedge clk);
        start_i = 1'b1; a_i = 64'd77; b_i = 64'd0; cc_en_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        finish_div();
        // R7 back-to-back: new start in the done cycle
        issue("R7", 0, 1, 32'd0, 64'd81, 64'd9);
        while (!done_o) @(negedge clk);
        start_i = 1'b1; signed_i = 1'b1; y_i = 32'hFFFF_FFFF; a_i = 64'hFFFF_FFF0; b_i = 64'd3;
        @(negedge clk);
        start_i = 1'b0;
        finish_div();
        // Mixed patterns
        for (int i = 0; i < 24; i++) begin
            logic [63:0] bb;
            bb = {$urandom, $urandom};
            if (i % 6 == 5) bb[31:0] = 32'd0;
            else if (i % 3 == 0) bb[31:0] = bb[31:0] >> (i % 29);
            do_div(i[0] ? "R4" : "R3", i[0], i[1], $urandom >> (i % 32), {$urandom, $urandom}, bb);
        end
        // R9 reset in the middle of a divide
        issue("R9", 0, 1, 32'd0, 64'd50, 64'd5);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule